// File: doc/BRIEF.md
# Video Timing Output Conditioner

This block sits between the internal video timing generator and the output pads. It takes the raw horizontal sync, vertical sync, blanking, field, pixel-valid and vertical-blank-data-valid flags, an interrupt request and a 16-bit pixel word. It registers all of them on the pixel clock and sets the active level of each flag from a programmable control byte. It also produces two pad-enable signals, one for the pixel bus and one for the timing group. The pad cells use these enables to three-state the pins.

A freeze request stops the timing outputs only at a field boundary, so a field is never cut part way through. Clearing the request has no effect until the next boundary, where normal timing resumes with the first cycle of the new field. While frozen, the sync, blank, field and vertical-blank-data flags keep the levels they had on the last cycle of the ending field. The pixel-valid flag is driven to its inactive level.

Top module: `vid_out_cond`

## Requirements
- R1: While `rstN` is low, `pixOe` and `timingOe` are 0, all six flag outputs are 1, `irqOut` is 0 and `pixOut` is 0.
- R2: `pixOut` equals `pixIn` and `pixOe` equals `ctrlByte[7]`, both one clock later.
- R3: `timingOe` equals `ctrlByte[6]` one clock later.
- R4: The polarity bits are `ctrlByte[5]` field, `[4]` blank, `[3]` hsync, `[2]` vsync, `[1]` pixel-valid and `[0]` vertical-blank-data-valid. When not frozen, each flag output shows its input one clock later. When its bit is 1, the output is high while the input is high; when its bit is 0, the output is the inverse of the input.
- R5: `irqOut` equals `irqIn` one clock later, with no polarity applied, frozen or not.
- R6: A field boundary is a clock at which `fieldIn` differs from its value at the previous clock. The previous value counts as 0 on the first clock after reset.
- R7: A `freezeReq` that is set and cleared with no field boundary in between has no effect on any output.
- R8: A boundary clock with `freezeReq` at 1 starts a freeze. From that clock on, the field, blank, hsync, vsync and vertical-blank-data-valid outputs hold the values they had before it. The pixel-valid output equals the inverse of `ctrlByte[1]`, one clock later.
- R9: A freeze ends only at a boundary clock with `freezeReq` at 0. The outputs then show that clock's inputs under R4. Clearing `freezeReq` between boundaries leaves the freeze in place.
- R10: A freeze has no effect on `pixOut`, `pixOe`, `timingOe` or `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlByte | input | 8 | Pad enables (bits 7, 6) and flag polarities (bits 5..0) |
| freezeReq | input | 1 | Request to freeze timing at the next field boundary |
| hsIn | input | 1 | Internal horizontal sync, high true |
| vsIn | input | 1 | Internal vertical sync, high true |
| blankIn | input | 1 | Internal blanking, high true |
| fieldIn | input | 1 | Internal field flag, high for the odd field |
| pixValidIn | input | 1 | Internal pixel-valid, high true |
| vbiValidIn | input | 1 | Internal vertical-blank-data-valid, high true |
| irqIn | input | 1 | Internal interrupt request |
| pixIn | input | 16 | Pixel word |
| pixOut | output | 16 | Registered pixel word |
| pixOe | output | 1 | Pad enable for the pixel bus |
| hsOut | output | 1 | Conditioned horizontal sync |
| vsOut | output | 1 | Conditioned vertical sync |
| blankOut | output | 1 | Conditioned blanking |
| fieldOut | output | 1 | Conditioned field flag |
| pixValidOut | output | 1 | Conditioned pixel-valid |
| vbiValidOut | output | 1 | Conditioned vertical-blank-data-valid |
| irqOut | output | 1 | Registered interrupt request |
| timingOe | output | 1 | Pad enable for the timing group |

## Verification
Two events can fall on the same clock: a field boundary and a change of the freeze request. The bench provokes this by waiting for the clock on which its field generator toggles `fieldIn` and changing `freezeReq` on that same clock, in both directions. It also changes the pixel-valid polarity while frozen, so the held flags and the forced idle level are judged in the same cycles. A behavioural model decides from the sampled inputs whether that clock started, kept or ended the freeze. Every output is compared with the model after every clock.

// File: rtl/vid_out_pkg.sv
package vid_out_pkg;
  localparam int NUM_FLAGS = 6;
  // flag slots match the polarity bits of the control byte
  localparam int FLD_IDX = 5;
  localparam int BLK_IDX = 4;
  localparam int HS_IDX  = 3;
  localparam int VS_IDX  = 2;
  localparam int DV_IDX  = 1;
  localparam int VBI_IDX = 0;
  localparam int PIX_OE_BIT = 7;
  localparam int TIM_OE_BIT = 6;

  typedef struct packed {
    logic capture;   // load new flag values this clock
    logic idleValid; // drive pixel-valid to its inactive level
  } pathStrb_t;
endpackage

// File: rtl/vid_freeze_ctrl.sv
module vid_freeze_ctrl
  import vid_out_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      freezeReq,
  input  logic      fieldIn,
  output pathStrb_t strb
);
  logic fieldPrev;
  logic frozen;
  logic fieldEdge;
  logic frozenNext;

  assign fieldEdge  = fieldIn ^ fieldPrev;
  assign frozenNext = frozen ? !(fieldEdge && !freezeReq)
                             : (fieldEdge && freezeReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldPrev <= 1'b0;
      frozen    <= 1'b0;
    end else begin
      fieldPrev <= fieldIn;
      frozen    <= frozenNext;
    end
  end

  always_comb begin
    strb.capture   = !frozenNext;
    strb.idleValid = frozenNext;
  end

  // R7
  no_early_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && !fieldEdge) |=> !frozen);
  // R9
  hold_to_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !fieldEdge) |=> frozen);
  // R8
  enter_on_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fieldEdge && freezeReq) |=> frozen);
endmodule

// File: rtl/vid_out_path.sv
module vid_out_path
  import vid_out_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pathStrb_t            strb,
  input  logic [7:0]           ctrlByte,
  input  logic [NUM_FLAGS-1:0] flagsIn,
  input  logic                 irqIn,
  input  logic [PIX_W-1:0]     pixIn,
  output logic [NUM_FLAGS-1:0] flagsQ,
  output logic                 irqQ,
  output logic [PIX_W-1:0]     pixQ,
  output logic                 pixOeQ,
  output logic                 timOeQ
);
  logic [NUM_FLAGS-1:0] polBits;
  assign polBits = ctrlByte[NUM_FLAGS-1:0];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    if (i == DV_IDX) begin : g_valid
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               flagsQ[i] <= 1'b1;
        else if (strb.capture)   flagsQ[i] <= flagsIn[i] ^ ~polBits[i];
        else if (strb.idleValid) flagsQ[i] <= ~polBits[i];
      end
      // R8
      idle_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.idleValid |=> (flagsQ[i] == !$past(polBits[i])));
    end else begin : g_timing
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             flagsQ[i] <= 1'b1;
        else if (strb.capture) flagsQ[i] <= flagsIn[i] ^ ~polBits[i];
      end
      // R8
      held_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strb.capture |=> $stable(flagsQ[i]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ   <= 1'b0;
      pixQ   <= '0;
      pixOeQ <= 1'b0;
      timOeQ <= 1'b0;
    end else begin
      irqQ   <= irqIn;
      pixQ   <= pixIn;
      pixOeQ <= ctrlByte[PIX_OE_BIT];
      timOeQ <= ctrlByte[TIM_OE_BIT];
    end
  end
endmodule

// File: rtl/vid_out_cond.sv
module vid_out_cond
  import vid_out_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       ctrlByte,
  input  logic             freezeReq,
  input  logic             hsIn,
  input  logic             vsIn,
  input  logic             blankIn,
  input  logic             fieldIn,
  input  logic             pixValidIn,
  input  logic             vbiValidIn,
  input  logic             irqIn,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] pixOut,
  output logic             pixOe,
  output logic             hsOut,
  output logic             vsOut,
  output logic             blankOut,
  output logic             fieldOut,
  output logic             pixValidOut,
  output logic             vbiValidOut,
  output logic             irqOut,
  output logic             timingOe
);
  pathStrb_t            strb;
  logic [NUM_FLAGS-1:0] flagsIn;
  logic [NUM_FLAGS-1:0] flagsQ;

  always_comb begin
    flagsIn          = '0;
    flagsIn[FLD_IDX] = fieldIn;
    flagsIn[BLK_IDX] = blankIn;
    flagsIn[HS_IDX]  = hsIn;
    flagsIn[VS_IDX]  = vsIn;
    flagsIn[DV_IDX]  = pixValidIn;
    flagsIn[VBI_IDX] = vbiValidIn;
  end

  vid_freeze_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .freezeReq (freezeReq),
    .fieldIn   (fieldIn),
    .strb      (strb)
  );

  vid_out_path #(.PIX_W(PIX_W)) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ctrlByte (ctrlByte),
    .flagsIn  (flagsIn),
    .irqIn    (irqIn),
    .pixIn    (pixIn),
    .flagsQ   (flagsQ),
    .irqQ     (irqOut),
    .pixQ     (pixOut),
    .pixOeQ   (pixOe),
    .timOeQ   (timingOe)
  );

  assign fieldOut    = flagsQ[FLD_IDX];
  assign blankOut    = flagsQ[BLK_IDX];
  assign hsOut       = flagsQ[HS_IDX];
  assign vsOut       = flagsQ[VS_IDX];
  assign pixValidOut = flagsQ[DV_IDX];
  assign vbiValidOut = flagsQ[VBI_IDX];

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |-> (!pixOe && !timingOe && !irqOut));
endmodule

// File: tb/vid_out_cond_tb.sv
module vid_out_cond_tb_top;
  localparam int FLEN = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ctrlByte = 8'h00;
  logic        freezeReq = 1'b0;
  logic        hsIn = 1'b0, vsIn = 1'b0, blankIn = 1'b0, fieldIn = 1'b0;
  logic        pixValidIn = 1'b0, vbiValidIn = 1'b0, irqIn = 1'b0;
  logic [15:0] pixIn = '0;
  logic [15:0] pixOut;
  logic        pixOe, hsOut, vsOut, blankOut, fieldOut;
  logic        pixValidOut, vbiValidOut, irqOut, timingOe;

  int total = 0;
  int bad = 0;
  int phase = 0;
  bit justToggled = 0;
  string reqTag = "R1";
  string dataTag = "R2";

  // model state: flags as {field, blank, hs, vs, valid, vbi}
  bit       mPrev, mFrozen;
  bit [5:0] mFlags;
  bit [15:0] mPix;
  bit mIrq, mPoe, mToe;

  always #2.5 clk = ~clk;

  vid_out_cond dut_i (
    .clk(clk), .rstN(rstN), .ctrlByte(ctrlByte), .freezeReq(freezeReq),
    .hsIn(hsIn), .vsIn(vsIn), .blankIn(blankIn), .fieldIn(fieldIn),
    .pixValidIn(pixValidIn), .vbiValidIn(vbiValidIn), .irqIn(irqIn),
    .pixIn(pixIn), .pixOut(pixOut), .pixOe(pixOe), .hsOut(hsOut),
    .vsOut(vsOut), .blankOut(blankOut), .fieldOut(fieldOut),
    .pixValidOut(pixValidOut), .vbiValidOut(vbiValidOut),
    .irqOut(irqOut), .timingOe(timingOe)
  );

  // reference model
  always @(posedge clk or negedge rstN) begin
    bit boundary;
    bit [5:0] raw;
    if (!rstN) begin
      mPrev = 0; mFrozen = 0; mFlags = 6'h3f;
      mPix = 0; mIrq = 0; mPoe = 0; mToe = 0;
    end else begin
      boundary = (fieldIn != mPrev);                 // R6
      mPrev = fieldIn;
      if (boundary) mFrozen = freezeReq;             // R8 / R9
      raw = {fieldIn, blankIn, hsIn, vsIn, pixValidIn, vbiValidIn};
      if (mFrozen) begin
        mFlags[1] = !ctrlByte[1];
      end else begin
        for (int k = 0; k < 6; k++)
          mFlags[k] = ctrlByte[k] ? raw[k] : !raw[k]; // R4
      end
      mPix = pixIn; mIrq = irqIn;
      mPoe = ctrlByte[7]; mToe = ctrlByte[6];
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(reqTag, {fieldOut, blankOut, hsOut, vsOut, pixValidOut, vbiValidOut}, mFlags);
    chk(dataTag, pixOut, mPix);
    chk(rstN ? "R2" : "R1", pixOe, mPoe);
    chk(rstN ? "R3" : "R1", timingOe, mToe);
    chk(rstN ? "R5" : "R1", irqOut, mIrq);
  endtask

  task automatic drive();
    hsIn = 1'($urandom); vsIn = 1'($urandom); blankIn = 1'($urandom);
    pixValidIn = 1'($urandom); vbiValidIn = 1'($urandom);
    irqIn = 1'($urandom); pixIn = 16'($urandom);
    justToggled = 0;
    phase++;
    if (phase == FLEN) begin
      phase = 0;
      fieldIn = ~fieldIn;
      justToggled = 1;
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      drive();
    end
  endtask

  task automatic toBoundary();
    cyc(1);
    while (!justToggled) cyc(1);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state
    reqTag = "R1";
    cyc(3);
    rstN = 1'b1;
    // R4: polarity patterns
    reqTag = "R4";
    ctrlByte = 8'hC0; cyc(50);
    ctrlByte = 8'hFF; cyc(50);
    ctrlByte = 8'hD5; cyc(30);
    ctrlByte = 8'hEA; cyc(30);
    // R3 / R2: pad enables
    ctrlByte = 8'h3F; cyc(8);
    ctrlByte = 8'h80; cyc(8);
    ctrlByte = 8'hC0; cyc(8);
    // R7: request pulse inside a field
    reqTag = "R7";
    toBoundary();
    cyc(5); freezeReq = 1; cyc(20); freezeReq = 0; cyc(20);
    // R8: freeze set on the boundary clock itself; R10 data keeps running
    reqTag = "R8"; dataTag = "R10";
    ctrlByte = 8'hFF;
    toBoundary();
    freezeReq = 1;
    cyc(10);
    ctrlByte = 8'hFD; cyc(10);   // pixel-valid polarity flips while frozen
    // R9: clear mid-field, freeze holds until boundary
    reqTag = "R9";
    cyc(5); freezeReq = 0;
    toBoundary();
    cyc(15);
    // R9: release exactly on the boundary clock
    freezeReq = 1;
    toBoundary();                // freeze entered here
    cyc(10);
    while (!justToggled) cyc(1); // reach next boundary
    freezeReq = 0;
    cyc(15);
    // R8: freeze held across a whole field
    reqTag = "R8";
    ctrlByte = 8'hC5; freezeReq = 1;
    toBoundary(); cyc(45); freezeReq = 0; toBoundary(); cyc(5);
    dataTag = "R2";
    // R6: boundary on the first clock after reset
    reqTag = "R6";
    rstN = 1'b0; cyc(2);
    fieldIn = 1'b1; phase = 0; freezeReq = 1;
    rstN = 1'b1;
    cyc(1); fieldIn = 1'b1; phase = 0;
    cyc(10); freezeReq = 0; toBoundary(); cyc(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule